// File: doc/BRIEF.md
# Scan-Line Ring Buffer with Host Refill Interrupt

This block stands in for a full frame store in a small video pipeline. It keeps a ring of a few complete scan lines in on-chip memory and reads one of them out at the pixel rate while an external timing generator drives the visible-area and sync signals. The host streams pixel bytes in through a byte-wide port with a valid strobe, such as the parallel output of a serial receiver. Each byte is one 8-bit pixel, and a line is `LINE_PIXELS` bytes long (640 by default).

At a horizontal sync the block raises a level interrupt once enough slots have been emptied. The host then has that many line periods to deliver the next lines. With two slots the host refills one line per line period. With four slots it refills three lines per batch, which gives it a longer, coarser deadline at the cost of more memory. If the display reaches a slot that the host has not finished, the block shows a black line, raises a sticky underrun flag and tries the same slot again on the next line.

Top module: `linebuf_refill`

## Requirements
- R1: After reset the pixel output is 0, and the refill interrupt and underrun flag are both low.
- R2: A completed slot is shown byte for byte in write order, one pixel per cycle of `vis_in`. Each pixel appears on `pix_out` one clock after the `vis_in` cycle it belongs to.
- R3: Completed slots are shown in the order in which they were filled, wrapping around the ring of `NUM_SLOTS` slots.
- R4: `pix_out` is 0 in every cycle whose `vis_in` (one clock earlier) was low. The read position does not advance outside the visible area, so each shown line starts at its byte 0.
- R5: `hs_out` and `vs_out` equal `hs_in` and `vs_in` delayed by one clock, so they line up with `pix_out`.
- R6: While all `NUM_SLOTS` slots hold complete lines that have not been shown, incoming bytes are dropped. No displayed or pending line is overwritten.
- R7: When a visible line starts and the current slot is not complete, that whole line is output as 0 and `underrun` goes high. The slot is not consumed, and it is shown on a later line once it is complete.
- R8: `underrun` stays high until `ur_clr` is sampled high. A new underrun in the same cycle wins over the clear.
- R9: On a rising edge of `hs_in`, `refill_irq` goes high if the number of empty slots is at least the batch size. The batch size is 1 for two slots and `NUM_SLOTS-1` for four slots. The interrupt then stays high until a byte is accepted.
- R10: A partly filled slot keeps its byte position across displayed lines. The remaining bytes complete the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host byte strobe |
| wr_byte | input | 8 | Host pixel byte |
| vis_in | input | 1 | Visible-area flag from the timing generator |
| hs_in | input | 1 | Horizontal sync in |
| vs_in | input | 1 | Vertical sync in |
| ur_clr | input | 1 | Clears the underrun flag |
| pix_out | output | 8 | Pixel out, 0 when blanked |
| hs_out | output | 1 | Horizontal sync, aligned to pixel |
| vs_out | output | 1 | Vertical sync, aligned to pixel |
| refill_irq | output | 1 | Level refill request |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench fills every slot and then pushes a further line while the ring is full. A design that overwrote a pending slot would show those dropped bytes in place of the black underrun line the bench expects. It also displays a half-written line and then finishes it. A design that consumed a slot on underrun, or that restarted the byte count, would show the wrong bytes or skip a line. After each of the four displayed lines the bench samples the interrupt, which catches a batch threshold that is off by one slot. Every pixel is compared one clock after its visible cycle, so an extra or missing read register shows up as shifted pixels.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

    typedef logic [7:0] pixel_t;

    typedef enum logic [1:0] {
        SCAN_IDLE,
        SCAN_SHOW,
        SCAN_BLACK
    } scan_mode_e;

    typedef struct packed {
        logic start;
        logic stop;
    } vis_edge_t;

    // Empty slots needed before the refill request is raised
    function automatic int unsigned irq_batch(input int unsigned slots);
        return (slots >= 4) ? slots - 1 : 1;
    endfunction

endpackage

// File: rtl/lbr_store.sv
module lbr_store
    import lbr_pkg::*;
#(
    parameter int DEPTH  = 2560,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  pixel_t            wdata,
    input  logic [ADDR_W-1:0] raddr,
    output pixel_t            rdata
);

    pixel_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/lbr_writer.sv
module lbr_writer
    import lbr_pkg::*;
#(
    parameter int LINE_PIXELS = 640,
    parameter int NUM_SLOTS   = 4,
    parameter int SLOT_W      = 2,
    parameter int COL_W       = 10,
    parameter int ADDR_W      = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic              blocked,
    output logic [SLOT_W-1:0] wr_slot,
    output logic              accept,
    output logic              fill_done,
    output logic [ADDR_W-1:0] waddr
);

    localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(LINE_PIXELS - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic [COL_W-1:0] byte_cnt;

    assign accept    = wr_valid && !blocked;
    assign fill_done = accept && (byte_cnt == LAST_COL);
    assign waddr     = ADDR_W'(wr_slot) * ADDR_W'(LINE_PIXELS) + ADDR_W'(byte_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_cnt <= '0;
            wr_slot  <= '0;
        end else if (accept) begin
            if (byte_cnt == LAST_COL) begin
                byte_cnt <= '0;
                wr_slot  <= (wr_slot == LAST_SLOT) ? '0 : wr_slot + 1'b1;
            end else begin
                byte_cnt <= byte_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lbr_scanner.sv
module lbr_scanner
    import lbr_pkg::*;
#(
    parameter int LINE_PIXELS = 640,
    parameter int NUM_SLOTS   = 4,
    parameter int SLOT_W      = 2,
    parameter int COL_W       = 10,
    parameter int ADDR_W      = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vis_in,
    input  logic              cur_full,
    output logic [SLOT_W-1:0] rd_slot,
    output logic [ADDR_W-1:0] raddr,
    output logic              release_slot,
    output logic              underrun_set,
    output logic              show
);

    localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(LINE_PIXELS - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic       vis_q;
    logic [COL_W-1:0] col;
    scan_mode_e mode, mode_now;
    vis_edge_t  edge_ev;

    always_comb begin
        edge_ev.start = vis_in && !vis_q;
        edge_ev.stop  = !vis_in && vis_q;
        if (edge_ev.start) begin
            mode_now = cur_full ? SCAN_SHOW : SCAN_BLACK;
        end else begin
            mode_now = mode;
        end
    end

    assign release_slot = edge_ev.stop && (mode == SCAN_SHOW);
    assign underrun_set = edge_ev.start && !cur_full;
    assign raddr        = ADDR_W'(rd_slot) * ADDR_W'(LINE_PIXELS) + ADDR_W'(col);

    always_ff @(posedge clk) begin
        if (rst) begin
            vis_q   <= 1'b0;
            mode    <= SCAN_IDLE;
            col     <= '0;
            rd_slot <= '0;
            show    <= 1'b0;
        end else begin
            vis_q <= vis_in;
            show  <= vis_in && (mode_now == SCAN_SHOW);
            if (vis_in) begin
                mode <= mode_now;
                if (col != LAST_COL) begin
                    col <= col + 1'b1;
                end
            end else begin
                mode <= SCAN_IDLE;
                col  <= '0;
                if (release_slot) begin
                    rd_slot <= (rd_slot == LAST_SLOT) ? '0 : rd_slot + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/linebuf_refill.sv
module linebuf_refill
    import lbr_pkg::*;
#(
    parameter int LINE_PIXELS = 640,
    parameter int NUM_SLOTS   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_valid,
    input  logic [7:0] wr_byte,
    input  logic       vis_in,
    input  logic       hs_in,
    input  logic       vs_in,
    input  logic       ur_clr,
    output logic [7:0] pix_out,
    output logic       hs_out,
    output logic       vs_out,
    output logic       refill_irq,
    output logic       underrun
);

    localparam int SLOT_W = (NUM_SLOTS > 2) ? $clog2(NUM_SLOTS) : 1;
    localparam int COL_W  = $clog2(LINE_PIXELS);
    localparam int DEPTH  = NUM_SLOTS * LINE_PIXELS;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(NUM_SLOTS + 1);
    localparam logic [CNT_W-1:0] BATCH = CNT_W'(irq_batch(NUM_SLOTS));

    logic [NUM_SLOTS-1:0] slot_full;
    logic [SLOT_W-1:0]    wr_slot, rd_slot;
    logic [ADDR_W-1:0]    waddr, raddr;
    logic                 wr_accept, fill_done, wr_blocked;
    logic                 release_slot, underrun_set, show, cur_full;
    logic                 hs_q;
    logic [CNT_W-1:0]     free_cnt;
    pixel_t               rdata;

    assign wr_blocked = slot_full[wr_slot];
    assign cur_full   = slot_full[rd_slot];
    assign free_cnt   = CNT_W'(NUM_SLOTS) - CNT_W'($countones(slot_full));

    lbr_writer #(
        .LINE_PIXELS(LINE_PIXELS), .NUM_SLOTS(NUM_SLOTS),
        .SLOT_W(SLOT_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
    ) u_writer (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .blocked(wr_blocked),
        .wr_slot(wr_slot), .accept(wr_accept), .fill_done(fill_done), .waddr(waddr)
    );

    lbr_scanner #(
        .LINE_PIXELS(LINE_PIXELS), .NUM_SLOTS(NUM_SLOTS),
        .SLOT_W(SLOT_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
    ) u_scanner (
        .clk(clk), .rst(rst), .vis_in(vis_in), .cur_full(cur_full),
        .rd_slot(rd_slot), .raddr(raddr), .release_slot(release_slot),
        .underrun_set(underrun_set), .show(show)
    );

    lbr_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .we(wr_accept), .waddr(waddr), .wdata(wr_byte),
        .raddr(raddr), .rdata(rdata)
    );

    // Per-slot occupancy: set when the writer completes it, cleared when shown
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_full[g] <= 1'b0;
            end else if (fill_done && (wr_slot == SLOT_W'(g))) begin
                slot_full[g] <= 1'b1;
            end else if (release_slot && (rd_slot == SLOT_W'(g))) begin
                slot_full[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q       <= 1'b0;
            refill_irq <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            hs_q <= hs_in;
            if (hs_in && !hs_q && (free_cnt >= BATCH)) begin
                refill_irq <= 1'b1;
            end else if (wr_accept) begin
                refill_irq <= 1'b0;
            end
            if (underrun_set) begin
                underrun <= 1'b1;
            end else if (ur_clr) begin
                underrun <= 1'b0;
            end
        end
    end

    // Sync pipeline matches the one-cycle memory read
    always_ff @(posedge clk) begin
        hs_out <= hs_in;
        vs_out <= vs_in;
    end

    assign pix_out = show ? rdata : 8'h00;

endmodule

// File: rtl/linebuf_refill_checker.sv
module linebuf_refill_checker (
    input logic       clk,
    input logic       rst,
    input logic       vis_in,
    input logic       hs_in,
    input logic       wr_valid,
    input logic       ur_clr,
    input logic [7:0] pix_out,
    input logic       hs_out,
    input logic       refill_irq,
    input logic       underrun,
    input logic       wr_blocked,
    input logic       wr_accept
);

    a_r4_blank_black: assert property (@(posedge clk) disable iff (rst)
        !$past(vis_in) |-> (pix_out == 8'h00));

    a_r5_hs_delay: assert property (@(posedge clk) disable iff (rst)
        hs_out == $past(hs_in));

    a_r6_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        wr_blocked |-> !wr_accept);

    a_r7_underrun_origin: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $past(vis_in));

    a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(underrun) && !$past(ur_clr)) |-> underrun);

    a_r9_irq_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(refill_irq) && !$past(wr_valid)) |-> refill_irq);

    a_r9_irq_origin: assert property (@(posedge clk) disable iff (rst)
        $rose(refill_irq) |-> $past(hs_in));

endmodule

bind linebuf_refill linebuf_refill_checker u_chk (
    .clk(clk), .rst(rst), .vis_in(vis_in), .hs_in(hs_in),
    .wr_valid(wr_valid), .ur_clr(ur_clr), .pix_out(pix_out),
    .hs_out(hs_out), .refill_irq(refill_irq), .underrun(underrun),
    .wr_blocked(wr_blocked), .wr_accept(wr_accept)
);

// File: tb/linebuf_refill_bench.sv
module linebuf_refill_bench;

    localparam int L = 16;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       vis_in = 1'b0;
    logic       hs_in = 1'b0;
    logic       vs_in = 1'b0;
    logic       ur_clr = 1'b0;
    logic [7:0] pix_out;
    logic       hs_out, vs_out, refill_irq, underrun;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0] mdl[$];     // accepted bytes not yet shown
    logic [7:0] exp_q[$];   // expected visible pixels

    always #5 clk = ~clk;

    linebuf_refill #(.LINE_PIXELS(L), .NUM_SLOTS(N)) u_linebuf_refill (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .vis_in(vis_in), .hs_in(hs_in), .vs_in(vs_in), .ur_clr(ur_clr),
        .pix_out(pix_out), .hs_out(hs_out), .vs_out(vs_out),
        .refill_irq(refill_irq), .underrun(underrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: output at a negedge belongs to vis/sync seen at the previous negedge
    logic prev_vis = 1'b0, prev_hs = 1'b0, prev_vs = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_vis) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected pixel", int'(pix_out), -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(pix_out == e, "R2/R3 pixel", int'(pix_out), int'(e));
                end
            end else begin
                chk(pix_out == 8'h00, "R4 blank pixel", int'(pix_out), 0);
            end
            chk(hs_out == prev_hs && vs_out == prev_vs, "R5 sync delay",
                int'({hs_out, vs_out}), int'({prev_hs, prev_vs}));
        end
        prev_vis = vis_in;
        prev_hs  = hs_in;
        prev_vs  = vs_in;
    end

    task automatic write_bytes(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_valid = 1'b1;
            wr_byte  = 8'(base + i);
            if (mdl.size() / L < N) mdl.push_back(8'(base + i));
        end
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    // Drives one visible line; returns whether an underrun is expected
    task automatic drive_line(output bit exp_ur);
        if (mdl.size() >= L) begin
            exp_ur = 1'b0;
            for (int i = 0; i < L; i++) exp_q.push_back(mdl.pop_front());
        end else begin
            exp_ur = 1'b1;
            for (int i = 0; i < L; i++) exp_q.push_back(8'h00);
        end
        for (int i = 0; i < L; i++) begin
            @(posedge clk); #1;
            vis_in = 1'b1;
        end
        @(posedge clk); #1;
        vis_in = 1'b0;
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic hsync_pulse();
        @(posedge clk); #1;
        hs_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        hs_in = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic clear_ur();
        @(posedge clk); #1;
        ur_clr = 1'b1;
        @(posedge clk); #1;
        ur_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit ur;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(pix_out == 8'h00 && !refill_irq && !underrun, "R1 reset state",
            int'({pix_out, refill_irq, underrun}), 0);

        // R7: nothing written, line is black and underrun set
        drive_line(ur);
        chk(underrun == ur, "R7 underrun on empty ring", int'(underrun), int'(ur));

        // R8: clear
        clear_ur();
        chk(!underrun, "R8 underrun cleared", int'(underrun), 0);

        // R9: all slots empty at hsync -> request
        vs_in = 1'b1;
        hsync_pulse();
        vs_in = 1'b0;
        chk(refill_irq, "R9 irq on hsync", int'(refill_irq), 1);
        write_bytes(1, 8'h40);
        chk(!refill_irq, "R9 irq drops on first byte", int'(refill_irq), 0);

        // Fill all four slots, then one line too many (R6)
        write_bytes(L - 1, 8'h41);
        write_bytes(L, 8'h60);
        write_bytes(L, 8'h80);
        write_bytes(L, 8'hA0);
        write_bytes(L, 8'hE0);
        chk(mdl.size() == N * L, "R6 model holds four lines", mdl.size(), N * L);

        // R2/R3 lines shown in order; R9 batch threshold of three
        for (int k = 0; k < N; k++) begin
            drive_line(ur);
            chk(underrun == 1'b0, "R3 no underrun while ring full", int'(underrun), 0);
            hsync_pulse();
            chk(refill_irq == (k >= 2), "R9 batch threshold", int'(refill_irq), int'(k >= 2));
        end

        // R6: the extra line was dropped, so the next line underruns
        drive_line(ur);
        chk(underrun == 1'b1 && ur, "R6 dropped bytes not shown", int'(underrun), 1);
        clear_ur();

        // R10: partial line keeps its position; R7 slot retried
        write_bytes(10, 8'h10);
        drive_line(ur);
        chk(underrun == 1'b1 && ur, "R7 partial slot underruns", int'(underrun), 1);
        clear_ur();
        write_bytes(L - 10, 8'h1A);
        drive_line(ur);
        chk(underrun == 1'b0 && !ur, "R10 completed slot shown", int'(underrun), 0);

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R2 all pixels seen", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule